// File: doc/BRIEF.md
# Receive Resource Descriptor Fetcher

This block fills the current receive buffer registers of a network receiver from a table of resource descriptors in memory. Each descriptor is four 16-bit words. Two of them give the 32-bit start address of a receive buffer area. The other two give the size of that area, counted in 16-bit words. The block reads one descriptor through a simple word-read bus master and checks it against the bus-width rules. If the descriptor passes, the block loads the buffer pointer and word count registers and moves its table read pointer on to the next descriptor.

A fetch has two possible starts. Software sets a command bit, and the block clears that bit when the fetch completes. The receive path signals that the current buffer area is used up, and the block fetches on its own. A request that arrives while a fetch is running is held and served by a second fetch right after. Each bus address is the upper-address input joined above the 16-bit table read pointer plus the field's byte offset.

Top module: `rx_rsrc_fetch`

## Requirements
- R1: After reset, buf_ptr, buf_wc, rd_ptr, cmd_bit, err_flag, fetch_done and rd_req are all 0.
- R2: A fetch is four reads at byte offsets 0, 2, 4 and 6 from rd_ptr, in this order: pointer low half, pointer high half, count low half, count high half. rd_req stays high with a stable rd_addr until rd_ack. Each following read is requested in the cycle after the previous acknowledge, with no gap.
- R3: rd_addr equals {upper_addr, (rd_ptr + 2*k) mod 2^16} for field k. The low half wraps at 16 bits.
- R4: A cmd_set pulse sets cmd_bit in the next cycle, which starts a fetch. fetch_done pulses for one cycle after the fourth acknowledge. cmd_bit reads 0 in the cycle after that pulse.
- R5: An area_done pulse starts a fetch without setting cmd_bit.
- R6: A descriptor that passes the checks sets buf_ptr = {high, low} of the pointer fields and buf_wc = {high, low} of the count fields. rd_ptr advances by 8. All three change in the cycle after fetch_done.
- R7: With mode32 = 1, a descriptor passes only if the pointer low field has bits 1 and 0 clear and the count low field has bit 0 clear. With mode32 = 0, only pointer bit 0 must be clear, and an odd count is accepted. A failing descriptor still pulses fetch_done and clears cmd_bit. It leaves buf_ptr, buf_wc and rd_ptr unchanged and sets err_flag.
- R8: err_flag stays 1 until reset, including across later passing fetches.
- R9: A cmd_set or area_done that arrives during a fetch is held. A second fetch starts after the first completes. A cmd_set held this way keeps cmd_bit at 1 until the second fetch completes.
- R10: ptr_load writes ptr_val into rd_ptr when no fetch is running. It is ignored while a fetch is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode32 | input | 1 | 1 selects 32-bit bus rules, 0 selects 16-bit rules |
| upper_addr | input | 16 | Upper half of every table address |
| ptr_load | input | 1 | Load pulse for the table read pointer |
| ptr_val | input | 16 | Value written by ptr_load |
| cmd_set | input | 1 | Software pulse that sets the fetch command bit |
| area_done | input | 1 | Pulse from the receive path: current buffer area used up |
| cmd_bit | output | 1 | Fetch command bit, cleared by the block |
| rd_req | output | 1 | Word read request |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_ack | input | 1 | Read acknowledge, rd_data valid in the same cycle |
| rd_data | input | 16 | Read data |
| buf_ptr | output | 32 | Current receive buffer start address |
| buf_wc | output | 32 | Current receive buffer size in 16-bit words |
| rd_ptr | output | 16 | Table read pointer (byte address, low half) |
| fetch_done | output | 1 | One-cycle pulse when a fetch completes |
| err_flag | output | 1 | Sticky descriptor rule violation |

## Verification
A field index that is off by one shows at once as a wrong rd_addr on the next request, and a swapped half shows as a wrong buf_ptr or buf_wc in the cycle after fetch_done. A lost pending request shows up a few cycles after the first fetch: rd_req never rises again, and cmd_bit drops while a command is still held. A wrong pass/fail decision shows in the cycle after fetch_done: either the registers and rd_ptr move when they should not, or err_flag stays low. The fetches use wait states of zero to two cycles, a pointer that wraps at 16 bits, and requests that arrive in the middle of a fetch.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
  localparam int unsigned FIELD_W    = 16;
  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned IDX_W      = $clog2(NUM_FIELDS);
  localparam int unsigned FULL_W     = 2 * FIELD_W;
  localparam int unsigned STRIDE     = 2 * NUM_FIELDS;  // bytes per descriptor

  typedef enum logic [1:0] {BS_IDLE, BS_READ, BS_DONE} burst_st_e;

  // Byte address of field idx of the descriptor at base.
  function automatic logic [FULL_W-1:0] tbl_addr(input logic [FIELD_W-1:0] hi,
                                                 input logic [FIELD_W-1:0] base,
                                                 input logic [IDX_W-1:0]   idx);
    logic [FIELD_W-1:0] off;
    off = FIELD_W'({idx, 1'b0});
    return {hi, base + off};
  endfunction

  // Bus-width rules on the low pointer half and the low count half.
  function automatic logic desc_ok(input logic               wide,
                                   input logic [FIELD_W-1:0] p_lo,
                                   input logic [FIELD_W-1:0] wc_lo);
    if (wide) return (p_lo[1:0] == 2'b00) && !wc_lo[0];
    return !p_lo[0];
  endfunction
endpackage

// File: rtl/rrf_req_ctl.sv
module rrf_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_set,
  input  logic area_done,
  input  logic burst_idle,
  input  logic burst_done,
  output logic start,
  output logic cmd_bit
);
  logic cmd_q, cmd_pend, serving_cmd, auto_pend;

  assign start   = burst_idle && (cmd_q || auto_pend);
  assign cmd_bit = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q       <= 1'b0;
      cmd_pend    <= 1'b0;
      serving_cmd <= 1'b0;
      auto_pend   <= 1'b0;
    end else begin
      if (burst_done && serving_cmd) begin
        cmd_q    <= cmd_pend || cmd_set;
        cmd_pend <= 1'b0;
      end else if (cmd_set) begin
        if (!burst_idle && serving_cmd) cmd_pend <= 1'b1;
        else                            cmd_q    <= 1'b1;
      end

      if (start)          serving_cmd <= cmd_q;
      else if (burst_done) serving_cmd <= 1'b0;

      if (start)          auto_pend <= area_done;
      else if (area_done) auto_pend <= 1'b1;
    end
  end

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bit && !burst_done |=> cmd_bit);  // R4
  AST_PEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done && cmd_pend |=> cmd_bit);  // R9
endmodule

// File: rtl/rrf_burst.sv
module rrf_burst
  import rrf_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic [FIELD_W-1:0]                   hi_addr,
  input  logic [FIELD_W-1:0]                   base,
  input  logic                                 rd_ack,
  input  logic [FIELD_W-1:0]                   rd_data,
  output logic                                 rd_req,
  output logic [FULL_W-1:0]                    rd_addr,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]   fld,
  output logic                                 idle,
  output logic                                 done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FIELDS - 1);

  burst_st_e        st;
  logic [IDX_W-1:0] idx;
  logic             take;

  assign rd_req  = (st == BS_READ);
  assign rd_addr = tbl_addr(hi_addr, base, idx);
  assign idle    = (st == BS_IDLE);
  assign done    = (st == BS_DONE);
  assign take    = rd_req && rd_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= BS_IDLE;
      idx <= '0;
    end else begin
      case (st)
        BS_IDLE: if (start) begin
          st  <= BS_READ;
          idx <= '0;
        end
        BS_READ: if (rd_ack) begin
          idx <= idx + 1'b1;
          if (idx == LAST) st <= BS_DONE;
        end
        default: st <= BS_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n)                               fld[g] <= '0;
      else if (take && idx == IDX_W'(g))        fld[g] <= rd_data;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));  // R2
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    take && idx != LAST |=> rd_req);  // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !rd_req);  // R4
endmodule

// File: rtl/rx_rsrc_fetch.sv
module rx_rsrc_fetch
  import rrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode32,
  input  logic [15:0]       upper_addr,
  input  logic              ptr_load,
  input  logic [15:0]       ptr_val,
  input  logic              cmd_set,
  input  logic              area_done,
  output logic              cmd_bit,
  output logic              rd_req,
  output logic [31:0]       rd_addr,
  input  logic              rd_ack,
  input  logic [15:0]       rd_data,
  output logic [31:0]       buf_ptr,
  output logic [31:0]       buf_wc,
  output logic [15:0]       rd_ptr,
  output logic              fetch_done,
  output logic              err_flag
);
  logic                               start, burst_idle, burst_done, fetch_ok;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fld;

  rrf_req_ctl u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_set    (cmd_set),
    .area_done  (area_done),
    .burst_idle (burst_idle),
    .burst_done (burst_done),
    .start      (start),
    .cmd_bit    (cmd_bit)
  );

  rrf_burst u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .hi_addr (upper_addr),
    .base    (rd_ptr),
    .rd_ack  (rd_ack),
    .rd_data (rd_data),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .fld     (fld),
    .idle    (burst_idle),
    .done    (burst_done)
  );

  assign fetch_ok   = desc_ok(mode32, fld[0], fld[2]);
  assign fetch_done = burst_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_ptr  <= '0;
      buf_wc   <= '0;
      rd_ptr   <= '0;
      err_flag <= 1'b0;
    end else if (burst_done) begin
      if (fetch_ok) begin
        buf_ptr <= {fld[1], fld[0]};
        buf_wc  <= {fld[3], fld[2]};
        rd_ptr  <= rd_ptr + FIELD_W'(STRIDE);
      end else begin
        err_flag <= 1'b1;
      end
    end else if (ptr_load && burst_idle) begin
      rd_ptr <= ptr_val;
    end
  end

  AST_ADDR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[31:16] == upper_addr);  // R3
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_done |=> $stable(buf_ptr) && $stable(buf_wc));  // R6
  AST_BAD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done && !fetch_ok |=> $stable(buf_ptr) && $stable(rd_ptr) && err_flag);  // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);  // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_done && !burst_idle |=> $stable(rd_ptr));  // R10
endmodule

// File: tb/rx_rsrc_fetch_bench.sv
module rx_rsrc_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n, mode32, ptr_load, cmd_set, area_done, rd_ack;
  logic [15:0] upper_addr, ptr_val, rd_data, rd_ptr;
  logic        cmd_bit, rd_req, fetch_done, err_flag;
  logic [31:0] rd_addr, buf_ptr, buf_wc;

  always #10 clk = ~clk;  // 50 MHz

  rx_rsrc_fetch u_rx_rsrc_fetch (
    .clk(clk), .rst_n(rst_n), .mode32(mode32), .upper_addr(upper_addr),
    .ptr_load(ptr_load), .ptr_val(ptr_val), .cmd_set(cmd_set), .area_done(area_done),
    .cmd_bit(cmd_bit), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .buf_ptr(buf_ptr), .buf_wc(buf_wc), .rd_ptr(rd_ptr),
    .fetch_done(fetch_done), .err_flag(err_flag)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [15:0] desc [4];
  logic [15:0] m_up, m_ptr;
  logic [31:0] m_bp, m_wc;
  logic        m_err;

  typedef struct packed {
    logic m32; logic [15:0] up, p0, p1, w0, w1; logic ok;
  } vec_t;
  localparam vec_t VEC [0:5] = '{
    '{1'b1, 16'h1000, 16'h2000, 16'h1234, 16'h0100, 16'h0000, 1'b1},
    '{1'b1, 16'h1000, 16'h2002, 16'h1234, 16'h0100, 16'h0000, 1'b0},
    '{1'b1, 16'h2222, 16'h3000, 16'h0001, 16'h0101, 16'h0000, 1'b0},
    '{1'b0, 16'h2222, 16'h2002, 16'h0055, 16'h0101, 16'h0002, 1'b1},
    '{1'b0, 16'h3333, 16'h2001, 16'h0055, 16'h0100, 16'h0000, 1'b0},
    '{1'b1, 16'h4444, 16'h4000, 16'hABCD, 16'hFFFE, 16'h0001, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=%0d cycles expected<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // poke: 0 none, 1 cmd_set, 2 area_done, 3 ptr_load, applied with the second ack
  task automatic serve(input int waits, input int poke);
    for (int k = 0; k < 4; k++) begin
      if (k == 0) while (!rd_req) @(negedge clk);
      chk("R2 request present", {31'd0, rd_req}, 32'd1);
      chk("R3 address", rd_addr, {m_up, m_ptr + 16'(2 * k)});
      for (int w = 0; w < waits; w++) begin
        @(negedge clk);
        chk("R2 hold during wait", {rd_req, rd_addr[30:0]}, {1'b1, m_up[14:0], m_ptr + 16'(2 * k)});
      end
      rd_ack = 1'b1; rd_data = desc[k];
      if (k == 1) begin
        cmd_set = (poke == 1); area_done = (poke == 2);
        ptr_load = (poke == 3); ptr_val = 16'h5550;
      end
      @(negedge clk);
      rd_ack = 1'b0; cmd_set = 1'b0; area_done = 1'b0; ptr_load = 1'b0;
    end
    chk("R4 fetch_done pulse", {31'd0, fetch_done}, 32'd1);
    @(negedge clk);
  endtask

  task automatic settle(input logic ok, input string tag);
    if (ok) begin
      m_bp = {desc[1], desc[0]}; m_wc = {desc[3], desc[2]}; m_ptr = m_ptr + 16'd8;
    end else m_err = 1'b1;
    chk({tag, " R6/R7 buf_ptr"}, buf_ptr, m_bp);
    chk({tag, " R6/R7 buf_wc"}, buf_wc, m_wc);
    chk({tag, " R6/R7 rd_ptr"}, {16'd0, rd_ptr}, {16'd0, m_ptr});
    chk({tag, " R7/R8 err_flag"}, {31'd0, err_flag}, {31'd0, m_err});
  endtask

  task automatic pulse_cmd();
    cmd_set = 1'b1; @(negedge clk); cmd_set = 1'b0;
    chk("R4 cmd_bit set", {31'd0, cmd_bit}, 32'd1);
  endtask

  task automatic set_desc(input logic [15:0] a, b, c, d);
    desc[0] = a; desc[1] = b; desc[2] = c; desc[3] = d;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 buf_ptr", buf_ptr, 0); chk("R1 buf_wc", buf_wc, 0);
    chk("R1 rd_ptr", {16'd0, rd_ptr}, 0);
    chk("R1 flags", {28'd0, cmd_bit, err_flag, fetch_done, rd_req}, 0);
    rst_n = 1'b1;
    m_bp = '0; m_wc = '0; m_ptr = '0; m_err = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    mode32 = 1'b1; upper_addr = 16'h0; ptr_load = 1'b0; ptr_val = 16'h0;
    cmd_set = 1'b0; area_done = 1'b0; rd_ack = 1'b0; rd_data = 16'h0;
    m_up = 16'h0;
    do_reset();

    ptr_load = 1'b1; ptr_val = 16'h0010; @(negedge clk); ptr_load = 1'b0;
    m_ptr = 16'h0010;
    chk("R10 idle load", {16'd0, rd_ptr}, 32'h10);

    for (int i = 0; i < 6; i++) begin
      mode32 = VEC[i].m32; upper_addr = VEC[i].up; m_up = VEC[i].up;
      set_desc(VEC[i].p0, VEC[i].p1, VEC[i].w0, VEC[i].w1);
      pulse_cmd();
      serve(i % 3, 0);
      chk("R4 cmd_bit cleared", {31'd0, cmd_bit}, 32'd0);
      settle(VEC[i].ok, "table");
    end

    // R5: automatic fetch on exhausted area
    mode32 = 1'b1;
    set_desc(16'h8000, 16'h0007, 16'h0200, 16'h0000);
    area_done = 1'b1; @(negedge clk); area_done = 1'b0;
    chk("R5 cmd_bit stays 0", {31'd0, cmd_bit}, 32'd0);
    serve(1, 0);
    settle(1'b1, "R5 auto");

    // R9: command during fetch is held
    set_desc(16'h9000, 16'h0008, 16'h0010, 16'h0000);
    pulse_cmd();
    serve(0, 1);
    chk("R9 cmd_bit still set", {31'd0, cmd_bit}, 32'd1);
    settle(1'b1, "R9 first");
    set_desc(16'hA000, 16'h0009, 16'h0020, 16'h0000);
    serve(2, 0);
    chk("R9 cmd_bit cleared", {31'd0, cmd_bit}, 32'd0);
    settle(1'b1, "R9 second");

    // R9: area_done during fetch is held
    set_desc(16'hB000, 16'h000A, 16'h0030, 16'h0000);
    pulse_cmd();
    serve(0, 2);
    settle(1'b1, "R9 area first");
    set_desc(16'hC000, 16'h000B, 16'h0040, 16'h0000);
    serve(0, 0);
    settle(1'b1, "R9 area second");

    // R10: load during fetch is ignored
    set_desc(16'hD000, 16'h000C, 16'h0050, 16'h0000);
    pulse_cmd();
    serve(1, 3);
    settle(1'b1, "R10 busy load");

    // R3: pointer wrap at 16 bits
    ptr_load = 1'b1; ptr_val = 16'hFFFC; @(negedge clk); ptr_load = 1'b0;
    m_ptr = 16'hFFFC;
    set_desc(16'hE000, 16'h000D, 16'h0060, 16'h0000);
    pulse_cmd();
    serve(0, 0);
    settle(1'b1, "R3 wrap");

    // R1: reset clears sticky state
    do_reset();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule